// File: doc/BRIEF.md
# Byte-Buffer DMA Handshake Sequencer

This block sits between a parallel-port byte buffer and a processor's DMA channel. It decides when a burst may take place, asks the processor for it, and then lets the processor's read and write strobes move bytes through a small internal FIFO. The parallel-port side pushes bytes in or pulls them out on its own port. The processor side reaches the same FIFO only during a granted burst.

The host's current link phase picks the transfer direction. In the drain direction (`link_rev` = 1), the parallel-port side fills the FIFO and the processor reads the bytes out. In the fill direction (`link_rev` = 0), the processor writes bytes in and the parallel-port side removes them. The sequencer raises a request together with a direction bit. It waits for the processor to grant the burst with acknowledge and chip select, and it ends the burst when the processor signals terminal count. It then rests for at least two idle clocks before it asks again.

Top module: `ecp_dma_seq`

## Requirements
- R1: While reset is held, `dma_req` = 0, `burst_err` = 0, `buf_empty` = 1, `buf_full` = 0 and `cpu_rdata` = 0.
- R2: From idle, the block raises `dma_req` one clock after it samples the condition for a request. In the drain direction (`link_rev` = 1) that condition is at least one stored byte, and `dma_dir` reads 1. In the fill direction (`link_rev` = 0) the condition is at least one free slot, and `dma_dir` reads 0. With no stored byte in drain, or no free slot in fill, the request stays low.
- R3: While `dma_req` is high, `dma_dir` does not change, even if `link_rev` changes.
- R4: A burst begins only at a clock edge where `dma_req` is high and both `dma_ack` and `cpu_cs` are sampled high. Strobes that come before the grant move no data.
- R5: In a drain burst, each clock with `cpu_rd` and `cpu_cs` high pops the oldest byte. That byte appears on `cpu_rdata` one clock later and holds there until the next accepted read.
- R6: In a fill burst, each clock with `cpu_wr` and `cpu_cs` high pushes `cpu_wdata`. The bytes leave on `port_rdata` in the order they were written.
- R7: Strobes with `cpu_cs` low are ignored. A write strobe in a drain burst and a read strobe in a fill burst are also ignored.
- R8: An accepted read on an empty FIFO, or an accepted write on a full FIFO, leaves the FIFO and `cpu_rdata` unchanged. It sets `burst_err`, which stays set until reset.
- R9: When `dma_tc` is sampled high while `dma_req` is high, `dma_req` is low after that edge and stays low for the following clock. If the request condition still holds, `dma_req` rises again on the edge after that.
- R10: The parallel-port side may push (`port_push`) only while the direction is drain, and may pop (`port_pop`) only while it is fill. A push when full or a pop when empty is ignored. `port_rdata` always shows the oldest stored byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_rev | input | 1 | Host link phase: 1 drain, 0 fill |
| port_push | input | 1 | Parallel-port side push request |
| port_wdata | input | 8 | Byte pushed by the parallel-port side |
| port_pop | input | 1 | Parallel-port side pop request |
| port_rdata | output | 8 | Oldest stored byte |
| buf_empty | output | 1 | FIFO holds no byte |
| buf_full | output | 1 | FIFO has no free slot |
| dma_req | output | 1 | DMA request to the processor |
| dma_dir | output | 1 | Direction of the requested burst: 1 drain, 0 fill |
| dma_ack | input | 1 | Processor DMA acknowledge |
| cpu_cs | input | 1 | Processor chip select |
| dma_tc | input | 1 | Processor terminal count |
| cpu_rd | input | 1 | Processor read strobe, one clock per byte |
| cpu_wr | input | 1 | Processor write strobe, one clock per byte |
| cpu_wdata | input | 8 | Byte written by the processor |
| cpu_rdata | output | 8 | Byte returned to the processor |
| burst_err | output | 1 | Sticky underflow or overflow flag |

## Verification
The properties assume that `dma_ack` and `dma_tc` reach the block as synchronous, clock-wide levels. They also assume that the processor ends every burst with terminal count and never simply drops acknowledge. The stimulus changes every input half a clock away from the sampling edge. It grants a burst only while the request is visible and pulses terminal count for exactly one clock. It steps the read and write strobes one clock per byte, so every accepted strobe corresponds to exactly one FIFO action.

// File: rtl/ecp_dma_seq_pkg.sv
package ecp_dma_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_REQ   = 2'd1,
    ST_BURST = 2'd2,
    ST_GAP   = 2'd3
  } seq_state_t;
endpackage

// File: rtl/ecp_dma_seq_rst_sync.sv
module ecp_dma_seq_rst_sync #(
  parameter int STAGES = 2  // two or more
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) chain_q <= '0;
    else              chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/ecp_dma_seq_fifo.sv
module ecp_dma_seq_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8   // power of two
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic             full
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             push_ok, pop_ok;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign head    = mem[rd_ptr_q];

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (push_ok) wr_ptr_d = wr_ptr_q + 1'b1;
    if (pop_ok)  rd_ptr_d = rd_ptr_q + 1'b1;
    if (push_ok && !pop_ok)      cnt_d = cnt_q + 1'b1;
    else if (pop_ok && !push_ok) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr_q] <= push_data;
  end

  AST_FIFO_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> full && $stable(wr_ptr_q));  // R8
endmodule

// File: rtl/ecp_dma_seq_ctrl.sv
module ecp_dma_seq_ctrl
  import ecp_dma_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic link_rev,
  input  logic buf_empty,
  input  logic buf_full,
  input  logic dma_ack,
  input  logic cpu_cs,
  input  logic dma_tc,
  output logic dma_req,
  output logic dma_dir,
  output logic burst
);
  seq_state_t state_q, state_d;
  logic       dir_q;
  logic       dir_en;
  logic       want_req;

  assign want_req = link_rev ? !buf_empty : !buf_full;
  assign dir_en   = (state_q == ST_IDLE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (want_req) state_d = ST_REQ;
      ST_REQ: begin
        if (dma_tc)                 state_d = ST_GAP;
        else if (dma_ack && cpu_cs) state_d = ST_BURST;
      end
      ST_BURST: if (dma_tc) state_d = ST_GAP;
      ST_GAP:   state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      dir_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (dir_en) dir_q <= link_rev;
    end
  end

  assign dma_req = (state_q == ST_REQ) || (state_q == ST_BURST);
  assign burst   = (state_q == ST_BURST);
  assign dma_dir = dir_q;

  AST_REQ_HAS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_req) |-> (dma_dir ? !$past(buf_empty) : !$past(buf_full)));  // R2
  AST_DIR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |=> (!dma_req || $stable(dma_dir)));  // R3
  AST_GRANT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(burst) |-> $past(dma_ack && cpu_cs));  // R4
  AST_TC_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && dma_tc) |=> !dma_req);  // R9
  AST_IDLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dma_req) |=> !dma_req);  // R9
endmodule

// File: rtl/ecp_dma_seq.sv
module ecp_dma_seq #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              link_rev,
  input  logic              port_push,
  input  logic [DATA_W-1:0] port_wdata,
  input  logic              port_pop,
  output logic [DATA_W-1:0] port_rdata,
  output logic              buf_empty,
  output logic              buf_full,
  output logic              dma_req,
  output logic              dma_dir,
  input  logic              dma_ack,
  input  logic              cpu_cs,
  input  logic              dma_tc,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              burst_err
);
  logic              rst_s;
  logic              burst;
  logic              rd_go, wr_go, err_set;
  logic              fifo_push, fifo_pop;
  logic [DATA_W-1:0] fifo_wdata, head;
  logic [DATA_W-1:0] rdata_q;
  logic              err_q;

  ecp_dma_seq_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk(clk), .rst_n_async(rst_n), .rst_n_sync(rst_s)
  );

  ecp_dma_seq_ctrl i_ctrl (
    .clk(clk), .rst_n(rst_s), .link_rev(link_rev),
    .buf_empty(buf_empty), .buf_full(buf_full),
    .dma_ack(dma_ack), .cpu_cs(cpu_cs), .dma_tc(dma_tc),
    .dma_req(dma_req), .dma_dir(dma_dir), .burst(burst)
  );

  // processor strobes count only inside a granted burst with chip select
  assign rd_go   = burst && cpu_cs && cpu_rd && dma_dir;
  assign wr_go   = burst && cpu_cs && cpu_wr && !dma_dir;
  assign err_set = (rd_go && buf_empty) || (wr_go && buf_full);

  // each direction owns one FIFO end per side
  assign fifo_push  = dma_dir ? port_push  : wr_go;
  assign fifo_wdata = dma_dir ? port_wdata : cpu_wdata;
  assign fifo_pop   = dma_dir ? rd_go      : port_pop;

  ecp_dma_seq_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) i_fifo (
    .clk(clk), .rst_n(rst_s), .push(fifo_push), .push_data(fifo_wdata),
    .pop(fifo_pop), .head(head), .empty(buf_empty), .full(buf_full)
  );

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      if (rd_go && !buf_empty) rdata_q <= head;
      if (err_set)             err_q   <= 1'b1;
    end
  end

  assign cpu_rdata  = rdata_q;
  assign burst_err  = err_q;
  assign port_rdata = head;

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_s)
    $past(burst_err) |-> burst_err);  // R8
  AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (!rst_s)
    !cpu_cs |=> $stable(cpu_rdata));  // R7
endmodule

// File: tb/test_ecp_dma_seq.sv
module test_ecp_dma_seq;
  localparam int W = 8;
  localparam int D = 8;

  logic clk = 1'b0;
  logic rst_n, link_rev, port_push, port_pop, dma_ack, cpu_cs, dma_tc, cpu_rd, cpu_wr;
  logic [W-1:0] port_wdata, cpu_wdata, port_rdata, cpu_rdata;
  logic buf_empty, buf_full, dma_req, dma_dir, burst_err;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #2 clk = ~clk;

  ecp_dma_seq #(.DATA_W(W), .DEPTH(D)) i_ecp_dma_seq (
    .clk(clk), .rst_n(rst_n), .link_rev(link_rev),
    .port_push(port_push), .port_wdata(port_wdata), .port_pop(port_pop),
    .port_rdata(port_rdata), .buf_empty(buf_empty), .buf_full(buf_full),
    .dma_req(dma_req), .dma_dir(dma_dir), .dma_ack(dma_ack), .cpu_cs(cpu_cs),
    .dma_tc(dma_tc), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .burst_err(burst_err)
  );

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      checks++; fails++;
      $display("FAIL R9 watchdog: cycles=%0d expected below %0d", cyc, 20000);
      summary();
      $finish;
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_reset(logic rev);
    rst_n = 1'b0; link_rev = rev;
    port_push = 0; port_pop = 0; dma_ack = 0; cpu_cs = 0; dma_tc = 0;
    cpu_rd = 0; cpu_wr = 0; port_wdata = '0; cpu_wdata = '0;
    repeat (3) step();
    check("R1 req", dma_req, 0);
    check("R1 err", burst_err, 0);
    check("R1 empty", buf_empty, 1);
    check("R1 full", buf_full, 0);
    check("R1 rdata", cpu_rdata, 0);
    rst_n = 1'b1;
    repeat (4) step();
  endtask

  task automatic grant();
    dma_ack = 1; cpu_cs = 1; step();
    dma_ack = 0; cpu_cs = 0;
  endtask

  task automatic t_drain();
    do_reset(1'b1);
    check("R2 no data no req", dma_req, 0);
    port_push = 1; port_wdata = 8'hA1; step();
    port_wdata = 8'hB2; step();
    port_wdata = 8'hC3; step();
    port_push = 0; step();
    check("R2 drain req", dma_req, 1);
    check("R2 drain dir", dma_dir, 1);
    cpu_cs = 1; cpu_rd = 1; step();          // R4 strobe before grant
    cpu_rd = 0; cpu_cs = 0;
    grant();
    cpu_rd = 1; step(); cpu_rd = 0;          // R7 no chip select
    check("R7 read without cs", cpu_rdata, 0);
    cpu_cs = 1; cpu_rd = 1; step();
    check("R4 R5 first byte", cpu_rdata, 8'hA1);
    step();
    check("R5 second byte", cpu_rdata, 8'hB2);
    link_rev = 0; step();
    check("R5 third byte", cpu_rdata, 8'hC3);
    check("R5 empty", buf_empty, 1);
    check("R8 no err yet", burst_err, 0);
    step();
    check("R8 underflow err", burst_err, 1);
    check("R8 rdata held", cpu_rdata, 8'hC3);
    cpu_rd = 0;
    check("R3 dir held", dma_dir, 1);
    check("R3 req held", dma_req, 1);
    cpu_wr = 1; cpu_wdata = 8'h55; step();   // R7 write in drain burst
    cpu_wr = 0; cpu_cs = 0;
    check("R7 write ignored in drain", buf_empty, 1);
    link_rev = 1;
    dma_tc = 1; step(); dma_tc = 0;
    check("R9 req drops", dma_req, 0);
    step();
    check("R8 err sticky", burst_err, 1);
  endtask

  task automatic t_fill();
    do_reset(1'b0);
    check("R2 fill req", dma_req, 1);
    check("R2 fill dir", dma_dir, 0);
    cpu_cs = 1; cpu_wr = 1; cpu_wdata = 8'h77; step();
    cpu_wr = 0; cpu_cs = 0;
    check("R4 write before grant", buf_empty, 1);
    grant();
    cpu_wr = 1; cpu_wdata = 8'h99; step();
    check("R7 write without cs", buf_empty, 1);
    link_rev = 1;
    cpu_cs = 1; cpu_wdata = 8'h10; step();
    cpu_wdata = 8'h20; step();
    cpu_wdata = 8'h30; step();
    cpu_wr = 0;
    cpu_rd = 1; step(); cpu_rd = 0; cpu_cs = 0;   // R7 read in fill burst
    check("R7 read ignored in fill", cpu_rdata, 0);
    check("R3 dir held on phase change", dma_dir, 0);
    link_rev = 0;
    port_push = 1; port_wdata = 8'hEE; step(); port_push = 0;
    dma_tc = 1; step(); dma_tc = 0;
    check("R9 low after tc", dma_req, 0);
    step();
    check("R9 low in gap", dma_req, 0);
    step();
    check("R9 rearm after gap", dma_req, 1);
    check("R6 head first", port_rdata, 8'h10);
    port_pop = 1; step();
    check("R6 head second", port_rdata, 8'h20);
    step();
    check("R6 head third", port_rdata, 8'h30);
    step(); port_pop = 0;
    check("R10 port push ignored in fill", buf_empty, 1);
    check("R8 no err", burst_err, 0);
  endtask

  task automatic t_overflow();
    do_reset(1'b0);
    grant();
    cpu_cs = 1; cpu_wr = 1;
    for (int i = 0; i < D; i++) begin
      cpu_wdata = W'(8'h40 + i); step();
    end
    check("R10 full", buf_full, 1);
    check("R8 no err at full", burst_err, 0);
    cpu_wdata = 8'hFF; step();
    cpu_wr = 0; cpu_cs = 0;
    check("R8 overflow err", burst_err, 1);
    dma_tc = 1; step(); dma_tc = 0;
    repeat (3) step();
    check("R2 full no fill req", dma_req, 0);
    for (int i = 0; i < D; i++) begin
      check("R6 overflow order", port_rdata, 8'h40 + i);
      port_pop = 1; step(); port_pop = 0;
    end
    check("R8 overflow byte dropped", buf_empty, 1);
    port_pop = 1; step(); port_pop = 0;
    check("R10 pop on empty ignored", buf_empty, 1);
  endtask

  initial begin
    t_drain();
    t_fill();
    t_overflow();
    summary();
    $finish;
  end
endmodule